// File: doc/BRIEF.md
# SPI Bus Trace Encoder

This block listens passively to a four-wire SPI bus: two data lines, a serial clock and an active-low chip select. A much faster system clock oversamples the four lines, which pass through a two-flop synchronizer and an edge detector. While the bus is selected, every rising serial-clock edge yields one 4-bit symbol that holds both data bits. Changes on chip select yield their own marker symbols, so frame boundaries can be recovered from a plain symbol stream.

Symbols are packed eight to a 32-bit word, first symbol in the top nibble. Words leave through a small FIFO on a valid/ready stream, which a DMA engine would normally drain. A start pulse arms the encoder. A stop pulse pads any partial word with filler, then emits a fixed run of all-ones words so that the last 2 KiB page downstream is complete. The serial clock must run slower than one sixth of the system clock.

Top module: `spi_trace_packer`

## Requirements
- R1: After reset, out_valid and overflow are 0 and the block is off: bus activity produces no words until a start pulse.
- R2: A start pulse while off arms the block. Capture begins only at the next chip-select falling edge, which emits the symbol 4'b0010. If chip select is already low when armed, nothing is emitted until it goes high and then low again.
- R3: bus_in bit 0 is data0, bit 1 is data1, bit 2 is the serial clock and bit 3 is chip select (active low). On each serial-clock low-to-high change while capturing with chip select low, the symbol {data0, data1, 2'b00} is emitted (data0 in symbol bit 3, data1 in bit 2).
- R4: A chip-select rising edge while capturing emits 4'b0001 and re-arms the block. While chip select is high, serial-clock edges produce no symbols.
- R5: Eight symbols form one 32-bit word. The first symbol is in bits [31:28] and the eighth in bits [3:0].
- R6: A stop pulse while armed or capturing first completes a partial word with 4'b1111 symbols, then emits FLUSH_WORDS (default 511) words of 32'hFFFFFFFF. The block is then off and ignores the bus until the next start. Stop while off and start while flushing have no effect.
- R7: While out_valid is 1 and out_ready is 0, out_valid and out_data hold. Words leave in the order they were formed.
- R8: Outside a flush, a completed word that meets a full FIFO is dropped and overflow goes to 1, staying there until reset. Flush words wait for space and are never dropped.
- R9: Only data symbols (low two bits 00), 4'b0010, 4'b0001 and 4'b1111 are ever emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 4 | Raw bus lines: [0] data0, [1] data1, [2] serial clock, [3] chip select (active low) |
| start_cmd | input | 1 | One-cycle pulse that arms tracing |
| stop_cmd | input | 1 | One-cycle pulse that ends tracing and starts the filler flush |
| out_data | output | 32 | Packed symbol word |
| out_valid | output | 1 | out_data holds a word |
| out_ready | input | 1 | Consumer accepts the word this cycle |
| overflow | output | 1 | Sticky flag: a word was dropped because the FIFO was full |

## Verification
The bench arms the encoder while chip select is already low. A design that reacts to the low level instead of a falling edge would emit data before any start marker. It stops with a three-symbol partial word and expects one padded word followed by exactly 511 filler words. An off-by-one flush counter, or padding that is skipped, shows up as a wrong count or a wrong first word. It stalls the consumer to fill the FIFO: a design that overwrote stored words, or failed to latch the overflow flag, would deliver wrong words or a clear flag. It also toggles the serial clock with chip select high, and again after the flush, where any emitted word is an error.

// File: rtl/spi_trace_pkg.sv
package spi_trace_pkg;

  localparam int SYM_W         = 4;
  localparam int WORD_W        = 32;
  localparam int SYMS_PER_WORD = WORD_W / SYM_W;
  localparam int CNT_W         = $clog2(SYMS_PER_WORD);

  // bus_in line positions
  localparam int PIN_D0  = 0;
  localparam int PIN_D1  = 1;
  localparam int PIN_SCK = 2;
  localparam int PIN_CSN = 3;

  localparam logic [SYM_W-1:0] SYM_SEL_ON  = 4'b0010;
  localparam logic [SYM_W-1:0] SYM_SEL_OFF = 4'b0001;
  localparam logic [SYM_W-1:0] SYM_FILL    = 4'b1111;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_FLUSH = 2'd3
  } trace_state_e;

  function automatic logic [SYM_W-1:0] data_symbol(input logic d0, input logic d1);
    return {d0, d1, 2'b00};
  endfunction

  function automatic logic sym_is_legal(input logic [SYM_W-1:0] s);
    return (s[1:0] == 2'b00) || (s == SYM_SEL_ON) || (s == SYM_SEL_OFF) || (s == SYM_FILL);
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic [WORD_W-SYM_W-1:0] acc,
                                                  input logic [SYM_W-1:0] s);
    return {acc, s};
  endfunction

endpackage

// File: rtl/spi_bus_sync.sv
module spi_bus_sync #(
  parameter int          W        = 4,
  parameter logic [W-1:0] IDLE_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= IDLE_VAL;
      sync_q <= IDLE_VAL;
      prev_q <= IDLE_VAL;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl  = sync_q;
  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/spi_trace_ctrl.sv
module spi_trace_ctrl
  import spi_trace_pkg::*;
#(
  parameter int FLUSH_WORDS = 511
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_cmd,
  input  logic               stop_cmd,
  input  logic [3:0]         lvl,
  input  logic [3:0]         rise,
  input  logic [3:0]         fall,
  input  logic [CNT_W-1:0]   pk_cnt,
  input  logic               fifo_full,
  output logic               sym_valid,
  output logic [SYM_W-1:0]   sym,
  output trace_state_e       state
);
  localparam int FC_W = $clog2(FLUSH_WORDS + 2);

  trace_state_e    st_q, st_d;
  logic [FC_W-1:0] left_q, left_d;
  logic            flush_push;

  assign flush_push = sym_valid && (pk_cnt == CNT_W'(SYMS_PER_WORD - 1));

  always_comb begin
    st_d      = st_q;
    left_d    = left_q;
    sym_valid = 1'b0;
    sym       = SYM_FILL;
    unique case (st_q)
      ST_OFF: begin
        if (start_cmd) st_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (stop_cmd) begin
          st_d   = ST_FLUSH;
          left_d = FC_W'(FLUSH_WORDS) + FC_W'(pk_cnt != '0);
        end else if (fall[PIN_CSN]) begin
          sym_valid = 1'b1;
          sym       = SYM_SEL_ON;
          st_d      = ST_CAPT;
        end
      end
      ST_CAPT: begin
        if (stop_cmd) begin
          st_d   = ST_FLUSH;
          left_d = FC_W'(FLUSH_WORDS) + FC_W'(pk_cnt != '0);
        end else if (rise[PIN_CSN]) begin
          sym_valid = 1'b1;
          sym       = SYM_SEL_OFF;
          st_d      = ST_ARMED;
        end else if (rise[PIN_SCK] && !lvl[PIN_CSN]) begin
          sym_valid = 1'b1;
          sym       = data_symbol(lvl[PIN_D0], lvl[PIN_D1]);
        end
      end
      ST_FLUSH: begin
        sym_valid = (left_q != '0) && !fifo_full;
        if (flush_push) begin
          left_d = left_q - FC_W'(1);
          if (left_q == FC_W'(1)) st_d = ST_OFF;
        end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      left_q <= '0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/spi_nib_packer.sv
module spi_nib_packer
  import spi_trace_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sym_valid,
  input  logic [SYM_W-1:0]  sym,
  output logic [CNT_W-1:0]  cnt,
  output logic              word_push,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-SYM_W-1:0] acc_q;
  logic [CNT_W-1:0]        cnt_q;

  assign word_push = sym_valid && (cnt_q == CNT_W'(SYMS_PER_WORD - 1));
  assign word      = pack_word(acc_q, sym);
  assign cnt       = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (sym_valid) begin
      acc_q <= {acc_q[WORD_W-2*SYM_W-1:0], sym};
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  input  logic         rd_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_q, rd_q;
  logic [AW:0]  used;
  logic         do_wr, do_rd;

  assign used     = wr_q - rd_q;
  assign full     = (used == (AW+1)'(DEPTH));
  assign rd_valid = (used != '0);
  assign rd_data  = mem[rd_q[AW-1:0]];
  assign do_wr    = wr_en && !full;
  assign do_rd    = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_q[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_wr) wr_q <= wr_q + (AW+1)'(1);
      if (do_rd) rd_q <= rd_q + (AW+1)'(1);
    end
  end
endmodule

// File: rtl/spi_trace_packer.sv
module spi_trace_packer
  import spi_trace_pkg::*;
#(
  parameter int FLUSH_WORDS = 511,
  parameter int FIFO_DEPTH  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_in,
  input  logic        start_cmd,
  input  logic        stop_cmd,
  output logic [31:0] out_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        overflow
);
  logic [3:0]        lvl, rise, fall;
  logic              sym_valid;
  logic [SYM_W-1:0]  sym;
  trace_state_e      state;
  logic [CNT_W-1:0]  pk_cnt;
  logic              word_push;
  logic [WORD_W-1:0] word;
  logic              fifo_full;
  logic              overflow_q;

  spi_bus_sync #(.W(4), .IDLE_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(bus_in),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  spi_trace_ctrl #(.FLUSH_WORDS(FLUSH_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .lvl(lvl), .rise(rise), .fall(fall),
    .pk_cnt(pk_cnt), .fifo_full(fifo_full),
    .sym_valid(sym_valid), .sym(sym), .state(state)
  );

  spi_nib_packer u_pack (
    .clk(clk), .rst_n(rst_n),
    .sym_valid(sym_valid), .sym(sym),
    .cnt(pk_cnt), .word_push(word_push), .word(word)
  );

  spi_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(word_push), .wr_data(word), .full(fifo_full),
    .rd_valid(out_valid), .rd_data(out_data), .rd_ready(out_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                      overflow_q <= 1'b0;
    else if (word_push && fifo_full) overflow_q <= 1'b1;
  end

  assign overflow = overflow_q;
endmodule

// File: rtl/spi_trace_checker.sv
module spi_trace_checker
  import spi_trace_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sym_valid,
  input logic [SYM_W-1:0] sym,
  input trace_state_e     state,
  input logic             word_push,
  input logic             fifo_full,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_data,
  input logic             overflow
);
  AST_LEGAL_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> sym_is_legal(sym)); // R9

  AST_DATA_ONLY_CAPTURING: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym[1:0] == 2'b00) |-> (state == ST_CAPT)); // R4

  AST_OFF_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF) |-> !sym_valid); // R1

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R8

  AST_FLUSH_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLUSH && word_push) |-> !fifo_full); // R8

  AST_FLUSH_FILLER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLUSH && sym_valid) |-> (sym == SYM_FILL)); // R6
endmodule

bind spi_trace_packer spi_trace_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .sym_valid(sym_valid), .sym(sym), .state(state),
  .word_push(word_push), .fifo_full(fifo_full),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .overflow(overflow)
);

// File: tb/tb_spi_trace_packer.sv
`timescale 1ns/1ps
module tb_spi_trace_packer;
  localparam int HALF = 4;
  localparam int NFLUSH = 511;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus = 4'b1000;
  logic        start_cmd = 1'b0, stop_cmd = 1'b0;
  logic [31:0] out_data;
  logic        out_valid, overflow;
  logic        out_ready = 1'b1;

  int checks = 0, fails = 0, cyc = 0, nwords = 0, nsym = 0;
  bit done = 1'b0;
  logic [31:0] got [0:1023];
  logic [3:0]  syms [0:127];

  always #2.5 clk = ~clk;

  spi_trace_packer dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .overflow(overflow)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (nwords < 1024) got[nwords] = out_data;
      nwords++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected under 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic add_sym(input logic [3:0] s);
    syms[nsym] = s;
    nsym++;
  endtask

  function automatic logic [31:0] exp_word(input int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 8; j++) w = {w[27:0], syms[8*k+j]};
    return w;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; bus = 4'b1000; start_cmd = 1'b0; stop_cmd = 1'b0; out_ready = 1'b1;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    nwords = 0; nsym = 0;
  endtask

  task automatic pulse_start(); start_cmd = 1'b1; tick(1); start_cmd = 1'b0; tick(1); endtask
  task automatic pulse_stop();  stop_cmd  = 1'b1; tick(1); stop_cmd  = 1'b0; tick(1); endtask

  // one serial bit; expected symbol recorded by the caller
  task automatic spi_bit(input logic a, input logic b);
    bus[0] = a; bus[1] = b;
    tick(HALF);
    bus[2] = 1'b1;
    tick(HALF);
    bus[2] = 1'b0;
  endtask

  task automatic sel(input logic low);
    bus[3] = ~low;
    tick(HALF);
  endtask

  task automatic test_reset();
    do_reset();
    chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk(overflow == 1'b0, "R1 overflow after reset", 32'(overflow), 32'd0);
    sel(1'b1);
    for (int i = 0; i < 20; i++) spi_bit(i[0], i[1]);
    sel(1'b0);
    tick(20);
    chk(nwords == 0, "R1 no words before start", 32'(nwords), 32'd0);
  endtask

  task automatic test_frame();
    do_reset();
    pulse_start();
    sel(1'b1); add_sym(4'b0010);
    for (int i = 0; i < 14; i++) begin
      spi_bit(i[0], i[1] ^ i[2]);
      add_sym({i[0], i[1] ^ i[2], 2'b00});
    end
    sel(1'b0); add_sym(4'b0001);
    tick(10);
    chk(nwords == 2, "R5 word count for 16 symbols", 32'(nwords), 32'd2);
    chk(got[0] == exp_word(0), "R3 R5 first word", got[0], exp_word(0));
    chk(got[1] == exp_word(1), "R4 R5 second word with end marker", got[1], exp_word(1));
    for (int i = 0; i < 16; i++) spi_bit(1'b1, 1'b1);
    tick(10);
    chk(nwords == 2, "R4 clock with select high ignored", 32'(nwords), 32'd2);
  endtask

  task automatic test_low_at_start();
    do_reset();
    sel(1'b1);
    pulse_start();
    for (int i = 0; i < 16; i++) spi_bit(1'b1, 1'b0);
    sel(1'b0);
    sel(1'b1); add_sym(4'b0010);
    for (int i = 0; i < 7; i++) begin
      spi_bit(i[1], i[0]);
      add_sym({i[1], i[0], 2'b00});
    end
    tick(10);
    chk(nwords == 1, "R2 one word after late falling edge", 32'(nwords), 32'd1);
    chk(got[0] == exp_word(0), "R2 word starts with select marker", got[0], exp_word(0));
  endtask

  task automatic test_stop_flush();
    int bad = 0;
    do_reset();
    pulse_start();
    sel(1'b1); add_sym(4'b0010);
    spi_bit(1'b1, 1'b0); add_sym(4'b1000);
    spi_bit(1'b0, 1'b1); add_sym(4'b0100);
    for (int i = 0; i < 5; i++) add_sym(4'b1111);
    pulse_stop();
    tick(4400);
    chk(nwords == NFLUSH + 1, "R6 padded word plus filler count", 32'(nwords), 32'(NFLUSH + 1));
    chk(got[0] == exp_word(0), "R6 partial word padded", got[0], exp_word(0));
    for (int i = 1; i <= NFLUSH; i++) if (got[i] != 32'hFFFF_FFFF) bad++;
    chk(bad == 0, "R6 filler words all ones", 32'(bad), 32'd0);
    sel(1'b0); sel(1'b1);
    for (int i = 0; i < 10; i++) spi_bit(1'b1, 1'b1);
    sel(1'b0);
    tick(10);
    chk(nwords == NFLUSH + 1, "R6 bus ignored after flush", 32'(nwords), 32'(NFLUSH + 1));
  endtask

  task automatic test_stop_empty();
    do_reset();
    pulse_stop();
    tick(10);
    chk(nwords == 0, "R6 stop while off ignored", 32'(nwords), 32'd0);
    pulse_start();
    pulse_stop();
    tick(4300);
    chk(nwords == NFLUSH, "R6 empty packer gives exact filler run", 32'(nwords), 32'(NFLUSH));
  endtask

  task automatic test_backpressure();
    logic [31:0] hold;
    do_reset();
    out_ready = 1'b0;
    pulse_start();
    sel(1'b1); add_sym(4'b0010);
    for (int i = 0; i < 15; i++) begin
      spi_bit(i[2], i[0]);
      add_sym({i[2], i[0], 2'b00});
    end
    tick(4);
    hold = out_data;
    chk(out_valid == 1'b1, "R7 valid raised under stall", 32'(out_valid), 32'd1);
    tick(12);
    chk(out_valid == 1'b1 && out_data == hold, "R7 word held under stall", out_data, hold);
    chk(hold == exp_word(0), "R7 oldest word first", hold, exp_word(0));
    out_ready = 1'b1;
    tick(6);
    chk(nwords == 2 && got[1] == exp_word(1), "R7 words in order", got[1], exp_word(1));
  endtask

  task automatic test_overflow();
    int bad = 0;
    do_reset();
    out_ready = 1'b0;
    pulse_start();
    sel(1'b1); add_sym(4'b0010);
    for (int i = 0; i < 47; i++) begin
      spi_bit(i[1] ^ i[3], i[0]);
      add_sym({i[1] ^ i[3], i[0], 2'b00});
    end
    tick(6);
    chk(overflow == 1'b1, "R8 overflow set on drop", 32'(overflow), 32'd1);
    out_ready = 1'b1;
    tick(12);
    chk(nwords == 4, "R8 only stored words delivered", 32'(nwords), 32'd4);
    for (int k = 0; k < 4; k++) if (got[k] != exp_word(k)) bad++;
    chk(bad == 0, "R8 stored words intact", 32'(bad), 32'd0);
    chk(overflow == 1'b1, "R8 overflow sticky", 32'(overflow), 32'd1);
  endtask

  initial begin
    test_reset();
    test_frame();
    test_low_at_start();
    test_stop_flush();
    test_stop_empty();
    test_backpressure();
    test_overflow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule